// File: doc/BRIEF.md
# Lockable Protected Memory Window Guard

This block sits between a requester and its backing RAM and guards one fixed address window so that, once armed, only privileged-mode accesses reach the RAM behind it. It owns a single byte-wide configuration register on a small configuration port. The register is set up with a two-step exchange. Software first asks whether the feature exists. It then locks the window. After the lock, the configuration state cannot change until the next reset.

Each access on the filter side carries a byte address, a write strobe, a privileged-mode flag and per-lane byte enables. While the window is locked, unprivileged bytes that fall inside the window are cut off from the RAM. Reads of those bytes return 0xFF and writes to them are dropped. All other bytes pass straight through. A static enable input turns the whole feature off. With the feature off, the register is an ordinary read/write byte and no byte is ever blocked. The filter path is combinational, and RAM read data is assumed to return in the same cycle.

Top module: `prot_window_guard`

## Requirements
- R1: After reset the register at configuration offset 0x9C reads 0x00, and every access reaches RAM unchanged regardless of mode.
- R2: While the register reads 0x00 with the feature enabled, a write of any value other than 0xFF is discarded and the register keeps reading 0x00.
- R3: While the register reads 0x00 with the feature enabled, writing 0xFF makes it read 0x01, and the window stays open.
- R4: While the register reads 0x01, a write with bit 1 clear leaves it at 0x01 and unlocked, and a write with bit 1 set (mask 0x02) locks the window so that the register reads 0x02.
- R5: Once locked, every configuration write is ignored and the register reads 0x02 until reset; after a reset it reads 0x00 and the window is open again.
- R6: While locked, any unprivileged byte whose address lies in [0x30000, 0x50000) reads as 0xFF, and its byte enable to RAM is cleared.
- R7: While locked, an unprivileged write loses the byte enables of in-window bytes, and RAM sees no access when no enabled byte is left.
- R8: Privileged accesses are forwarded to RAM with the same address, byte enables and data, whether or not the window is locked.
- R9: Bytes outside the window are forwarded unchanged in every state and mode.
- R10: The decode is made per byte: lane i of an access at byte address A covers address A+i, and in an access that straddles a window edge only the lanes inside the window are blocked.
- R11: With the feature input low, the register reads back any value written to it, and no access is ever blocked.
- R12: Configuration writes to any offset other than 0x9C have no effect, and reads of other offsets return 0x00.
- R13: A configuration write takes effect at the clock edge that samples it, so the very next access after a lock write is already filtered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| feat_en | input | 1 | Static feature enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| acc_valid | input | 1 | Access request valid |
| acc_we | input | 1 | Access is a write |
| acc_priv | input | 1 | Access comes from privileged mode |
| acc_addr | input | 32 | Byte address of lane 0 |
| acc_be | input | 4 | Byte enables, one per lane |
| acc_wdata | input | 32 | Write data, lane i in bits 8i+7:8i |
| acc_rdata | output | 32 | Read data returned to the requester |
| ram_valid | output | 1 | Forwarded access valid |
| ram_we | output | 1 | Forwarded write strobe |
| ram_addr | output | 32 | Forwarded byte address |
| ram_be | output | 4 | Forwarded byte enables after filtering |
| ram_wdata | output | 32 | Forwarded write data |
| ram_rdata | input | 32 | RAM read data, same cycle |

## Verification
A wrong handshake state shows up on cfg_rdata at the first read after the configuration write that caused it. It shows up on the filter side at the first access that touches the window: a lock missing or taken too early either leaks RAM data or returns 0xFF bytes. A bad per-lane decode shows at once in ram_be and in the mix of 0xFF and RAM bytes on acc_rdata. The straddling accesses at both window edges pick out an off-by-one. Because the filter is combinational, every error appears in the same cycle as the access.

// File: rtl/wg_pkg.sv
// Package: shared state encoding and handshake codes for the window guard.
// Assumes: one-byte configuration register, lock request carried in one bit.
package wg_pkg;
    typedef enum logic [1:0] {
        GS_OPEN    = 2'd0,
        GS_QUERIED = 2'd1,
        GS_LOCKED  = 2'd2
    } guard_state_e;

    localparam logic [7:0] QUERY_CODE = 8'hFF;
    localparam logic [7:0] ACK_CODE   = 8'h01;
    localparam logic [7:0] LOCK_CODE  = 8'h02;
    localparam int         LOCK_BIT   = 1;
    localparam logic [7:0] MASK_ALL   = 8'hFF;
    localparam logic [7:0] MASK_NONE  = 8'h00;
endpackage

// File: rtl/wg_cfg_reg.sv
// Module: configuration register with the run-time write mask and the
// query/lock handshake. Assumes feat_en is static between resets.
// Outputs the read data for the addressed offset and the lock flag.
module wg_cfg_reg
    import wg_pkg::*;
#(
    parameter int          CAW        = 8,
    parameter logic [CAW-1:0] CFG_OFFSET = 8'h9C
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           feat_en,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [7:0]     cfg_wdata,
    output logic [7:0]     cfg_rdata,
    output logic           locked
);
    guard_state_e state_q;
    logic [7:0]   wmask_q;
    logic [7:0]   plain_q;
    logic         hit;
    logic [7:0]   merged;
    logic [7:0]   reg_value;

    // Decode a write aimed at this register.
    always_comb hit = cfg_we && (cfg_addr == CFG_OFFSET);

    // Merge the write into the acknowledged value through the current mask.
    always_comb merged = (ACK_CODE & ~wmask_q) | (cfg_wdata & wmask_q);

    // Handshake state, write mask and plain byte update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_OPEN;
            wmask_q <= MASK_ALL;
            plain_q <= 8'h00;
        end else if (hit) begin
            if (!feat_en) begin
                plain_q <= cfg_wdata;
            end else begin
                unique case (state_q)
                    GS_OPEN: begin
                        if (cfg_wdata == QUERY_CODE) begin
                            state_q <= GS_QUERIED;
                            wmask_q <= LOCK_CODE;
                        end
                    end
                    GS_QUERIED: begin
                        if (merged[LOCK_BIT]) begin
                            state_q <= GS_LOCKED;
                            wmask_q <= MASK_NONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Visible register value for the current mode and state.
    always_comb begin
        if (!feat_en) begin
            reg_value = plain_q;
        end else begin
            unique case (state_q)
                GS_QUERIED: reg_value = ACK_CODE;
                GS_LOCKED:  reg_value = LOCK_CODE;
                default:    reg_value = 8'h00;
            endcase
        end
    end

    // Read mux: only the owned offset returns data.
    always_comb cfg_rdata = (cfg_addr == CFG_OFFSET) ? reg_value : 8'h00;

    // Lock flag seen by the filter.
    always_comb locked = feat_en && (state_q == GS_LOCKED);

    // R5: the lock holds until reset.
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && feat_en) |=> locked);

    // R2: a non-query write in the open state leaves the state open.
    a_r2_open_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_en && hit && state_q == GS_OPEN && cfg_wdata != QUERY_CODE)
        |=> state_q == GS_OPEN);

    // R4: a write with the lock bit clear after the query keeps the state.
    a_r4_query_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_en && hit && state_q == GS_QUERIED && !cfg_wdata[LOCK_BIT])
        |=> state_q == GS_QUERIED);

    // R12: writes to other offsets change nothing.
    a_r12_other_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != CFG_OFFSET) |=> ($stable(state_q) && $stable(plain_q)));
endmodule

// File: rtl/wg_lane_decode.sv
// Module: per-byte window hit decode. Lane i covers byte address addr+i;
// the sum is widened by one bit so that it never wraps.
module wg_lane_decode #(
    parameter int              AW     = 32,
    parameter int              LANES  = 4,
    parameter logic [AW:0]     W_BASE = 33'h0_0003_0000,
    parameter logic [AW:0]     W_SIZE = 33'h0_0002_0000
) (
    input  logic [AW-1:0]    addr,
    output logic [LANES-1:0] in_win
);
    localparam logic [AW:0] W_END = W_BASE + W_SIZE;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [AW:0] lane_addr;
        // Address of this lane and its window comparison.
        always_comb begin
            lane_addr = {1'b0, addr} + (AW+1)'(i);
            in_win[i] = (lane_addr >= W_BASE) && (lane_addr < W_END);
        end
    end
endmodule

// File: rtl/wg_access_filter.sv
// Module: steers each lane either to RAM or to the local all-ones sink.
// Assumes RAM read data for the forwarded lanes arrives in the same cycle.
module wg_access_filter #(
    parameter int LANES = 4,
    localparam int DW   = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             acc_valid,
    input  logic             acc_we,
    input  logic             acc_priv,
    input  logic [LANES-1:0] acc_be,
    input  logic [DW-1:0]    acc_wdata,
    input  logic [LANES-1:0] in_win,
    input  logic [DW-1:0]    ram_rdata,
    output logic [DW-1:0]    acc_rdata,
    output logic             ram_valid,
    output logic             ram_we,
    output logic [LANES-1:0] ram_be,
    output logic [DW-1:0]    ram_wdata
);
    logic [LANES-1:0] blocked;

    // Lanes that go to the sink.
    always_comb blocked = (locked && !acc_priv) ? in_win : '0;

    // Forwarded request with blocked lanes stripped.
    always_comb begin
        ram_be    = acc_be & ~blocked;
        ram_valid = acc_valid && (|ram_be);
        ram_we    = acc_we;
        ram_wdata = acc_wdata;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_rd
        // Per-lane read data: sink bytes are all ones.
        always_comb acc_rdata[i*8 +: 8] = blocked[i] ? 8'hFF : ram_rdata[i*8 +: 8];
    end

    // R8: privileged accesses keep every byte enable.
    a_r8_priv_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_priv) |-> (ram_be == acc_be));

    // R7: a locked unprivileged access never enables an in-window byte.
    a_r7_no_window_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && locked && !acc_priv) |-> ((ram_be & in_win) == '0));

    // R9: out-of-window lanes are never stripped.
    a_r9_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> ((acc_be & ~in_win) == (ram_be & ~in_win)));
endmodule

// File: rtl/prot_window_guard.sv
// Module: top of the lockable protected window guard. Joins the
// configuration register, the per-lane window decode and the filter.
// Assumes a synchronous active-low reset and a static feat_en.
module prot_window_guard
    import wg_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          LANES      = 4,
    parameter int          CAW        = 8,
    parameter logic [CAW-1:0] CFG_OFFSET = 8'h9C,
    parameter logic [AW:0] W_BASE     = 33'h0_0003_0000,
    parameter logic [AW:0] W_SIZE     = 33'h0_0002_0000,
    localparam int         DW         = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_en,
    input  logic             cfg_we,
    input  logic [CAW-1:0]   cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             acc_valid,
    input  logic             acc_we,
    input  logic             acc_priv,
    input  logic [AW-1:0]    acc_addr,
    input  logic [LANES-1:0] acc_be,
    input  logic [DW-1:0]    acc_wdata,
    output logic [DW-1:0]    acc_rdata,
    output logic             ram_valid,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [LANES-1:0] ram_be,
    output logic [DW-1:0]    ram_wdata,
    input  logic [DW-1:0]    ram_rdata
);
    logic             locked;
    logic [LANES-1:0] in_win;

    wg_cfg_reg #(.CAW(CAW), .CFG_OFFSET(CFG_OFFSET)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .feat_en   (feat_en),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .locked    (locked)
    );

    wg_lane_decode #(.AW(AW), .LANES(LANES), .W_BASE(W_BASE), .W_SIZE(W_SIZE)) dec_i (
        .addr   (acc_addr),
        .in_win (in_win)
    );

    wg_access_filter #(.LANES(LANES)) flt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (locked),
        .acc_valid (acc_valid),
        .acc_we    (acc_we),
        .acc_priv  (acc_priv),
        .acc_be    (acc_be),
        .acc_wdata (acc_wdata),
        .in_win    (in_win),
        .ram_rdata (ram_rdata),
        .acc_rdata (acc_rdata),
        .ram_valid (ram_valid),
        .ram_we    (ram_we),
        .ram_be    (ram_be),
        .ram_wdata (ram_wdata)
    );

    // Address passes through untouched.
    always_comb ram_addr = acc_addr;

    // R11: with the feature off the window is never locked.
    a_r11_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |-> !locked);
endmodule

// File: tb/prot_window_guard_tb.sv
// Bench: directed handshake steps plus seeded random accesses near the window.
module prot_window_guard_tb_top;
    localparam int          LANES = 4;
    localparam logic [32:0] WB    = 33'h0_0003_0000;
    localparam logic [32:0] WE    = 33'h0_0005_0000;
    localparam logic [7:0]  OFS   = 8'h9C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = OFS;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0, acc_we = 1'b0, acc_priv = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        ram_valid, ram_we;
    logic [31:0] ram_addr;
    logic [3:0]  ram_be;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int m_state = 0;      // 0 open, 1 queried, 2 locked
    logic [7:0] m_plain = 8'h00;

    always #2 clk = ~clk;

    prot_window_guard dut_i (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_we(acc_we), .acc_priv(acc_priv), .acc_addr(acc_addr),
        .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .ram_valid(ram_valid), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    function automatic logic [7:0] pat(input logic [32:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // RAM model: each byte is a function of its address.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            ram_rdata[i*8 +: 8] = pat({1'b0, ram_addr} + 33'(i));
    end

    function automatic logic [7:0] exp_reg();
        if (!feat_en) return m_plain;
        case (m_state)
            1: return 8'h01;
            2: return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [3:0] exp_block(input logic [31:0] a, input logic priv);
        logic [3:0] b;
        for (int i = 0; i < LANES; i++) begin
            logic [32:0] la;
            la = {1'b0, a} + 33'(i);
            b[i] = feat_en && (m_state == 2) && !priv && (la >= WB) && (la < WE);
        end
        return b;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_state = 0;
        m_plain = 8'h00;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = OFS;
        if (a == OFS) begin
            if (!feat_en) m_plain = d;
            else if (m_state == 0 && d == 8'hFF) m_state = 1;
            else if (m_state == 1 && d[1]) m_state = 2;
        end
    endtask

    task automatic cfg_check(input string req);
        #1;
        chk(req, {24'h0, cfg_rdata}, {24'h0, exp_reg()});
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic we,
                          input logic priv, input logic [3:0] be);
        logic [3:0]  blk;
        logic [31:0] erd;
        logic [3:0]  ebe;
        @(negedge clk);
        acc_valid = 1'b1; acc_we = we; acc_priv = priv; acc_addr = a; acc_be = be;
        acc_wdata = $urandom;
        #1;
        blk = exp_block(a, priv);
        ebe = be & ~blk;
        for (int i = 0; i < LANES; i++)
            erd[i*8 +: 8] = blk[i] ? 8'hFF : pat({1'b0, a} + 33'(i));
        chk({req, " be"}, {28'h0, ram_be}, {28'h0, ebe});
        chk({req, " valid"}, {31'h0, ram_valid}, {31'h0, |ebe});
        chk({req, " addr"}, ram_addr, a);
        if (we) chk({req, " wdata"}, ram_wdata, acc_wdata);
        else    chk({req, " rdata"}, acc_rdata, erd);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [31:0] near_addr();
        case ($urandom_range(0, 3))
            0: return 32'h0002_FFF0 + $urandom_range(0, 31);
            1: return 32'h0004_FFF0 + $urandom_range(0, 31);
            2: return 32'h0003_0000 + $urandom_range(0, 32'h1FFFF);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20190917));
        // Phase with the feature enabled.
        feat_en = 1'b1;
        do_reset();
        cfg_check("R1 reset value");
        access("R1 open read", 32'h0003_0000, 1'b0, 1'b0, 4'hF);
        access("R1 open write", 32'h0003_1000, 1'b1, 1'b0, 4'hF);
        for (int k = 0; k < 20; k++) begin
            cfg_write(OFS, 8'($urandom_range(0, 254)));
            cfg_check("R2 junk discarded");
        end
        cfg_write(8'h9D, 8'hFF);
        cfg_check("R12 other offset write");
        cfg_addr = 8'h9D;
        #1 chk("R12 other offset read", {24'h0, cfg_rdata}, 32'h0);
        cfg_addr = OFS;
        cfg_write(OFS, 8'hFF);
        cfg_check("R3 query ack");
        access("R3 still open", 32'h0003_0004, 1'b0, 1'b0, 4'hF);
        cfg_write(OFS, 8'h01);
        cfg_check("R4 bit1 clear");
        cfg_write(OFS, 8'hFD);
        cfg_check("R4 bit1 clear again");
        access("R4 unlocked open", 32'h0004_0000, 1'b0, 1'b0, 4'hF);
        cfg_write(OFS, 8'h02);
        cfg_check("R4 lock");
        access("R13 first access blocked", 32'h0003_0000, 1'b0, 1'b0, 4'hF);
        for (int k = 0; k < 30; k++) begin
            cfg_write(OFS, 8'($urandom));
            cfg_check("R5 locked write ignored");
        end
        access("R6 window read", 32'h0004_FFFC, 1'b0, 1'b0, 4'hF);
        access("R7 window write", 32'h0003_8000, 1'b1, 1'b0, 4'h3);
        access("R8 priv read", 32'h0003_8000, 1'b0, 1'b1, 4'hF);
        access("R8 priv write", 32'h0003_8000, 1'b1, 1'b1, 4'h6);
        access("R9 below window", 32'h0002_FFF0, 1'b0, 1'b0, 4'hF);
        access("R9 above window", 32'h0005_0000, 1'b1, 1'b0, 4'hF);
        access("R10 low edge", 32'h0002_FFFE, 1'b0, 1'b0, 4'hF);
        access("R10 high edge", 32'h0004_FFFE, 1'b1, 1'b0, 4'hF);
        for (int k = 0; k < 300; k++)
            access("R6 R7 R8 R9 R10 random", near_addr(), 1'($urandom), 1'($urandom),
                   4'($urandom_range(1, 15)));
        do_reset();
        cfg_check("R5 reset unlocks");
        access("R5 open after reset", 32'h0003_0000, 1'b0, 1'b0, 4'hF);

        // Phase with the feature disabled.
        feat_en = 1'b0;
        do_reset();
        cfg_check("R11 reset value");
        for (int k = 0; k < 20; k++) begin
            cfg_write(OFS, 8'($urandom));
            cfg_check("R11 plain readback");
        end
        cfg_write(OFS, 8'hFF);
        cfg_check("R11 no query");
        cfg_write(OFS, 8'h02);
        cfg_check("R11 no lock");
        for (int k = 0; k < 50; k++)
            access("R11 never blocked", near_addr(), 1'($urandom), 1'b0,
                   4'($urandom_range(1, 15)));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule